// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block collects four interrupt request lines into a latched pending register and qualifies each pending bit with a mask bit that software owns. A fixed-order priority encoder picks the lowest-numbered qualified source. A status flop records every clock edge whether any qualified request exists. Together with a software-owned enable flop, that status flop drives one interrupt line towards the processor.

When the processor acknowledges, the block places a vector on its output bus. The vector's two low bits hold the winning source number and every other bit is zero. In the same clock edge the block drops its enable flop, so no second interrupt is presented until software enables it again.

Software reaches the block through a single write port with a 2-bit operation code. The port loads the mask, clears chosen pending bits, sets the enable flop and clears it. Service routines can therefore clear the serviced source, narrow the mask to hold off lower levels, and later restore the mask.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Among qualified sources (pending AND mask), source 0 has the highest priority and source 3 the lowest. The encoded winner is the index of the lowest-numbered qualified source.
- R2: A source whose mask bit is 0 is never selected. Masked requests alone never raise `cpu_irq`.
- R3: While `intack` is 1, `vec_out` equals the winning source index in bits [1:0], with bits [7:2] zero. While `intack` is 0, `vec_out` is all zero. With no qualified source, the acknowledged vector is 0.
- R4: The status flop is loaded every clock edge with "any qualified source pending". `cpu_irq` therefore rises on the second edge after the cycle in which a request is presented, and it falls on the second edge after the cycle in which the last qualified pending bit is cleared.
- R5: The enable flop changes only through writes (`wr_op` 2 sets it, `wr_op` 3 clears it) and through acknowledge. Without either, it holds its value.
- R6: `cpu_irq` is 1 exactly when both the enable flop and the status flop are 1.
- R7: An edge with `intack` = 1 clears the enable flop. This takes precedence over a set written in the same cycle.
- R8: A request that is high for one cycle sets its pending bit on that edge. The bit stays set until it is explicitly cleared.
- R9: `wr_op` 1 clears every pending bit whose `wr_data` bit is 1. If a request arrives on the same bit in the same cycle, the bit stays set.
- R10: A synchronous reset (`rst` = 1 at an edge) clears the pending bits, the mask, the enable flop and the status flop.
- R11: `wr_op` 0 replaces the whole mask with `wr_data`. Lower-priority bits can be cleared and later restored, and a source that is still pending is presented again once its mask bit returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 4 | Request lines, bit i is source i |
| wr_en | input | 1 | Write strobe for the control port |
| wr_op | input | 2 | 0 mask load, 1 pending clear, 2 enable set, 3 enable clear |
| wr_data | input | 4 | Mask value or pending-clear bit map |
| intack | input | 1 | Interrupt acknowledge from the processor |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector address, driven only during acknowledge |

## Verification
Pending bits and the enable flop respond on the first edge after their stimulus. The status flop, and with it `cpu_irq`, responds on the second edge. The vector is combinational from `intack` and appears in the same cycle. The bench drives every input 1 ns after a rising edge and samples 1 ns after the edge that should carry the result. For `cpu_irq` it also samples after the first edge, to show that the status flop has not yet moved. Vector checks are taken while `intack` is held, before the edge that clears the enable flop, and the dropped interrupt is checked after that edge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   // control port operation codes
   typedef enum logic [1:0] {
      OP_MASK_LOAD = 2'd0,
      OP_PEND_CLR  = 2'd1,
      OP_IEN_SET   = 2'd2,
      OP_IEN_CLR   = 2'd3
   } cfg_op_e;

endpackage

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst) begin
            pend_o[g] <= 1'b0;
         end else if (req_i[g]) begin
            pend_o[g] <= 1'b1;
         end else if (clr_i[g]) begin
            pend_o[g] <= 1'b0;
         end
      end

      AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(req_i[g])) |-> pend_o[g]); // R8

      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(clr_i[g]) && !$past(req_i[g])) |-> !pend_o[g]); // R9
   end

endmodule

// File: rtl/prio_irq_enc.sv
module prio_irq_enc #(
   parameter int NUM_SRC = 4,
   localparam int CODE_W = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] eff_i,
   output logic               valid_o,
   output logic [CODE_W-1:0]  code_o
);

   // scan from the lowest priority up so that the lowest index wins
   always_comb begin
      code_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (eff_i[i]) begin
            code_o = CODE_W'(i);
         end
      end
   end

   assign valid_o = |eff_i;

   logic [NUM_SRC-1:0] below;
   assign below = (NUM_SRC'(1) << code_o) - NUM_SRC'(1);

   always_comb begin
      if (valid_o) begin
         AST_ENC_LOWEST: assert (eff_i[code_o] && ((eff_i & below) == '0)); // R1
      end
   end

endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 4,
   localparam int CODE_W = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [1:0]         wr_op,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic               intack,
   input  logic               enc_valid,
   input  logic [CODE_W-1:0]  enc_code,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic               ien_o,
   output logic               ist_o,
   output logic [CODE_W-1:0]  code_o
);

   cfg_op_e op;
   assign op = cfg_op_e'(wr_op);

   assign clr_o = (wr_en && op == OP_PEND_CLR) ? wr_data : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_o <= '0;
      end else if (wr_en && op == OP_MASK_LOAD) begin
         mask_o <= wr_data;
      end
   end

   // acknowledge outranks a program write to the enable flop
   always_ff @(posedge clk) begin
      if (rst) begin
         ien_o <= 1'b0;
      end else if (intack) begin
         ien_o <= 1'b0;
      end else if (wr_en && op == OP_IEN_SET) begin
         ien_o <= 1'b1;
      end else if (wr_en && op == OP_IEN_CLR) begin
         ien_o <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ist_o  <= 1'b0;
         code_o <= '0;
      end else begin
         ist_o  <= enc_valid;
         code_o <= enc_valid ? enc_code : '0;
      end
   end

   AST_ACK_DROPS_IEN: assert property (@(posedge clk) disable iff (rst)
      $past(intack) |-> !ien_o); // R7

   AST_IEN_HELD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(wr_en) && !$past(intack)) |-> $stable(ien_o)); // R5

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_SRC = 4,
   parameter int VEC_W   = 8,
   localparam int CODE_W = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               wr_en,
   input  logic [1:0]         wr_op,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic               intack,
   output logic               cpu_irq,
   output logic [VEC_W-1:0]   vec_out
);

   if (NUM_SRC < 2) begin : g_bad_src
      $error("prio_irq_ctrl: NUM_SRC must be at least 2");
   end
   if (VEC_W < CODE_W) begin : g_bad_vec
      $error("prio_irq_ctrl: VEC_W too narrow for the source code");
   end

   logic [NUM_SRC-1:0] pend, mask, clr, eff;
   logic               enc_valid, ien, ist;
   logic [CODE_W-1:0]  enc_code, code_q;

   prio_irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk   (clk),
      .rst   (rst),
      .req_i (irq_req),
      .clr_i (clr),
      .pend_o(pend)
   );

   assign eff = pend & mask;

   prio_irq_enc #(.NUM_SRC(NUM_SRC)) u_enc (
      .eff_i  (eff),
      .valid_o(enc_valid),
      .code_o (enc_code)
   );

   prio_irq_ctl #(.NUM_SRC(NUM_SRC)) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_op    (wr_op),
      .wr_data  (wr_data),
      .intack   (intack),
      .enc_valid(enc_valid),
      .enc_code (enc_code),
      .mask_o   (mask),
      .clr_o    (clr),
      .ien_o    (ien),
      .ist_o    (ist),
      .code_o   (code_q)
   );

   assign cpu_irq = ien & ist;
   assign vec_out = intack ? VEC_W'(code_q) : '0;

   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $rose(cpu_irq) |-> ($past(|(pend & mask)) || $past(ist))); // R2

   AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (ist == $past(|(pend & mask)))); // R4

endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] irq_req;
   logic       wr_en;
   logic [1:0] wr_op;
   logic [3:0] wr_data;
   logic       intack;
   logic       cpu_irq;
   logic [7:0] vec_out;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst(rst), .irq_req(irq_req), .wr_en(wr_en),
      .wr_op(wr_op), .wr_data(wr_data), .intack(intack),
      .cpu_irq(cpu_irq), .vec_out(vec_out)
   );

   // {req, mask, expected code, expected irq}
   localparam logic [10:0] TBL [12] = '{
      {4'hF, 4'hF, 2'd0, 1'b1},
      {4'hE, 4'hF, 2'd1, 1'b1},
      {4'hC, 4'hF, 2'd2, 1'b1},
      {4'h8, 4'hF, 2'd3, 1'b1},
      {4'hF, 4'hE, 2'd1, 1'b1},
      {4'hF, 4'h8, 2'd3, 1'b1},
      {4'h1, 4'hE, 2'd0, 1'b0},
      {4'hA, 4'h5, 2'd0, 1'b0},
      {4'h6, 4'h6, 2'd1, 1'b1},
      {4'h9, 4'h9, 2'd0, 1'b1},
      {4'h0, 4'hF, 2'd0, 1'b0},
      {4'hC, 4'h4, 2'd2, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] op, input logic [3:0] d);
      wr_en = 1'b1; wr_op = op; wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(input logic [3:0] r);
      irq_req = r;
      tick();
      irq_req = '0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; irq_req = '0; wr_en = 1'b0; wr_op = '0; wr_data = '0; intack = 1'b0;
      repeat (3) tick();
      rst = 1'b0;
      #1;
      chk("R10 reset irq", cpu_irq, 0);
      intack = 1'b1; #1;
      chk("R10 reset vector", vec_out, 0);
      intack = 1'b0; #1;

      // table walk: priority, masking, vector format
      foreach (TBL[k]) begin
         wr(2'd1, 4'hF);
         wr(2'd0, TBL[k][6:3]);
         wr(2'd2, 4'h0);
         pulse(TBL[k][10:7]);
         tick();
         chk($sformatf("R2/R6 irq row %0d", k), cpu_irq, TBL[k][0]);
         intack = 1'b1; #1;
         chk($sformatf("R1/R3 vector row %0d", k), vec_out, {6'b0, TBL[k][2:1]});
         tick();
         intack = 1'b0; #1;
         chk($sformatf("R7 irq after ack row %0d", k), cpu_irq, 0);
         chk($sformatf("R3 idle vector row %0d", k), vec_out, 0);
      end

      // R4 status lag, R8 latching
      wr(2'd1, 4'hF); wr(2'd0, 4'hF); wr(2'd2, 4'h0);
      irq_req = 4'h4; tick(); irq_req = '0;
      chk("R4 irq one edge after request", cpu_irq, 0);
      tick();
      chk("R4 irq two edges after request", cpu_irq, 1);
      repeat (3) tick();
      chk("R8 request stays latched", cpu_irq, 1);

      // R9 clear racing a new request on the same bit
      wr_en = 1'b1; wr_op = 2'd1; wr_data = 4'h4; irq_req = 4'h4;
      tick();
      wr_en = 1'b0; wr_data = '0; irq_req = '0;
      tick();
      chk("R9 new request beats clear", cpu_irq, 1);
      wr(2'd1, 4'h4);
      tick();
      chk("R9 clear drops pending", cpu_irq, 0);

      // R5 / R7 enable flop
      pulse(4'h2); tick();
      chk("R5 irq pending source 1", cpu_irq, 1);
      wr(2'd3, 4'h0);
      chk("R5 enable clear write", cpu_irq, 0);
      wr(2'd2, 4'h0);
      chk("R5 enable set write", cpu_irq, 1);
      intack = 1'b1; wr_en = 1'b1; wr_op = 2'd2;
      tick();
      intack = 1'b0; wr_en = 1'b0; #1;
      chk("R7 ack beats enable set", cpu_irq, 0);
      tick(); tick();
      chk("R5 enable held without write", cpu_irq, 0);
      wr(2'd2, 4'h0);
      chk("R5 enable set again", cpu_irq, 1);

      // R11 mask narrowing and restore
      wr(2'd1, 4'hF);
      pulse(4'h5); tick();
      intack = 1'b1; #1;
      chk("R1 source 0 over source 2", vec_out, 8'h00);
      tick(); intack = 1'b0; #1;
      wr(2'd2, 4'h0);
      wr(2'd0, 4'h1);
      wr(2'd1, 4'h1);
      tick();
      chk("R11 lower level held by mask", cpu_irq, 0);
      wr(2'd0, 4'hF);
      tick();
      chk("R11 mask restored presents source 2", cpu_irq, 1);
      intack = 1'b1; #1;
      chk("R11 restored vector", vec_out, 8'h02);
      tick(); intack = 1'b0; #1;

      // R10 reset with work in flight
      wr(2'd2, 4'h0);
      rst = 1'b1; tick(); rst = 1'b0; #1;
      chk("R10 irq after mid reset", cpu_irq, 0);
      wr(2'd0, 4'hF); wr(2'd2, 4'h0); tick();
      chk("R10 pending cleared by reset", cpu_irq, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule